// File: doc/BRIEF.md
# Frame Pointer Address Generator

This block produces data-memory addresses of the form base plus offset. A 16-bit base register and an 8-bit offset register are loaded and read back through a small register port. Each memory access is presented on a valid/ready request channel. The request carries a direction (read or write) and a modify mode (none, step up or step down). Every accepted access yields one address on a valid/ready result channel and may adjust the offset as a side effect.

The direction decides when the offset step takes effect. A read addresses memory with the offset as it stood, and the step lands afterwards. A write applies the step first and addresses memory with the stepped value. The offset wraps within its own eight bits, so no carry or borrow ever reaches the base. The address sum is kept to 16 bits.

Back-pressure works as follows. The result channel holds one address. `acc_ready` is high when that slot is empty or is being drained in the same cycle (`fp_ready` high). While `fp_valid` is high and `fp_ready` is low, `fp_addr` holds its value and further requests wait. A request that is not accepted has no effect on the offset.

Top module: `fpag_top`

## Requirements
- R1: After reset the base reads 0000h, the offset reads 00h and `fp_valid` is low.
- R2: A register write with `reg_wr_sel`=0 loads the base from `reg_wdata`. With `reg_wr_sel`=1 it loads the offset from `reg_wdata[7:0]`. `reg_rdata` shows the base when `reg_rd_sel`=0 and the zero-extended offset when `reg_rd_sel`=1, from the cycle after the write onward.
- R3: An accepted read access (`acc_is_wr`=0) yields an address equal to the base plus the offset held before the access.
- R4: On an accepted read, mode 01 adds one to the offset and mode 10 subtracts one, applied after the address is formed.
- R5: On an accepted write access (`acc_is_wr`=1), mode 01 or 10 steps the offset by +1 or -1 first. The address is the base plus the stepped offset.
- R6: Offset steps wrap in 8 bits (FFh+1 gives 00h, 00h-1 gives FFh) and leave the base unchanged.
- R7: Mode 00 and mode 11 leave the offset unchanged. In both cases the address uses the current offset.
- R8: A register write to the offset in the same cycle as an accepted access wins over the access's step. The access's address is still formed from the registers as they stood before that cycle.
- R9: `acc_ready` equals NOT `fp_valid` OR `fp_ready`. While `fp_valid` is high and `fp_ready` is low, `fp_valid` and `fp_addr` hold. An access that is not accepted changes nothing.
- R10: The address is the 16-bit sum with any carry out of bit 15 dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | Write target: 0 base, 1 offset |
| reg_wdata | input | 16 | Register write data |
| reg_rd_sel | input | 1 | Read target: 0 base, 1 offset |
| reg_rdata | output | 16 | Selected register contents |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request accepted this cycle when high with valid |
| acc_is_wr | input | 1 | Access direction: 1 write, 0 read |
| acc_mode | input | 2 | Modify mode: 00 none, 01 increment, 10 decrement, 11 none |
| fp_valid | output | 1 | Address result valid |
| fp_ready | input | 1 | Downstream accepts the address |
| fp_addr | output | 16 | Effective frame-pointer address |
| offs_out | output | 8 | Current offset register contents |

## Verification
Reads and writes are issued in each of the four modes, so a swap of pre-step and post-step timing shows up as an address off by one in one direction only. The offset is parked at FFh and at 00h, and the base near FFFFh, to separate correct 8-bit wrapping from carries that leak into the base or past bit 15. Offset writes that collide with stepping accesses test the priority rule. Random stalls on `fp_ready` show whether a held address stays stable and whether a refused request leaves the offset alone.

// File: rtl/fpag_pkg.sv
package fpag_pkg;
  typedef enum logic [1:0] {
    MOD_NONE = 2'b00,
    MOD_INC  = 2'b01,
    MOD_DEC  = 2'b10,
    MOD_RSVD = 2'b11
  } fp_mod_e;

  localparam logic SEL_BASE = 1'b0;
  localparam logic SEL_OFFS = 1'b1;
endpackage

// File: rtl/fpag_step.sv
// Offset modifier: wraps inside OFFS_W bits, no carry out.
module fpag_step #(
  parameter int OFFS_W = 8
) (
  input  logic [OFFS_W-1:0] offs_i,
  input  logic [1:0]        mode_i,
  output logic [OFFS_W-1:0] offs_o
);
  import fpag_pkg::*;

  fp_mod_e mode;
  assign mode = fp_mod_e'(mode_i);

  always_comb begin
    unique case (mode)
      MOD_INC: offs_o = offs_i + OFFS_W'(1);
      MOD_DEC: offs_o = offs_i - OFFS_W'(1);
      default: offs_o = offs_i;
    endcase
  end
endmodule

// File: rtl/fpag_sum.sv
// Address adder: reads use the old offset, writes the stepped one.
module fpag_sum #(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFFS_W-1:0] offs_old_i,
  input  logic [OFFS_W-1:0] offs_new_i,
  input  logic              is_wr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int PAD_W = ADDR_W - OFFS_W;

  logic [OFFS_W-1:0] offs_sel;
  assign offs_sel = is_wr_i ? offs_new_i : offs_old_i;
  assign addr_o   = base_i + {{PAD_W{1'b0}}, offs_sel};
endmodule

// File: rtl/fpag_regs.sv
// Base and offset registers; a direct offset write beats a step.
module fpag_regs #(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              step_en_i,
  input  logic [OFFS_W-1:0] offs_step_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [OFFS_W-1:0] offs_o
);
  import fpag_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_o <= '0;
      offs_o <= '0;
    end else begin
      if (wr_en_i && wr_sel_i == SEL_BASE)
        base_o <= wdata_i;
      if (wr_en_i && wr_sel_i == SEL_OFFS)
        offs_o <= wdata_i[OFFS_W-1:0];
      else if (step_en_i)
        offs_o <= offs_step_i;
    end
  end
endmodule

// File: rtl/fpag_out.sv
// One-entry result slot with valid/ready.
module fpag_out #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              space_o
);
  assign space_o = !valid_o || ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fpag_top.sv
module fpag_top #(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_wr_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              reg_rd_sel,
  output logic [ADDR_W-1:0] reg_rdata,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              acc_is_wr,
  input  logic [1:0]        acc_mode,
  output logic              fp_valid,
  input  logic              fp_ready,
  output logic [ADDR_W-1:0] fp_addr,
  output logic [OFFS_W-1:0] offs_out
);
  import fpag_pkg::*;

  localparam int PAD_W = ADDR_W - OFFS_W;

  logic [ADDR_W-1:0] base_q;
  logic [OFFS_W-1:0] offs_q;
  logic [OFFS_W-1:0] offs_step;
  logic [ADDR_W-1:0] addr_next;
  logic              fire;

  assign fire = acc_valid && acc_ready;

  fpag_step #(.OFFS_W(OFFS_W)) u_step (
    .offs_i (offs_q),
    .mode_i (acc_mode),
    .offs_o (offs_step)
  );

  fpag_sum #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_sum (
    .base_i     (base_q),
    .offs_old_i (offs_q),
    .offs_new_i (offs_step),
    .is_wr_i    (acc_is_wr),
    .addr_o     (addr_next)
  );

  fpag_regs #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (reg_wr_en),
    .wr_sel_i    (reg_wr_sel),
    .wdata_i     (reg_wdata),
    .step_en_i   (fire),
    .offs_step_i (offs_step),
    .base_o      (base_q),
    .offs_o      (offs_q)
  );

  fpag_out #(.ADDR_W(ADDR_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (fire),
    .addr_i  (addr_next),
    .ready_i (fp_ready),
    .valid_o (fp_valid),
    .addr_o  (fp_addr),
    .space_o (acc_ready)
  );

  assign offs_out  = offs_q;
  assign reg_rdata = (reg_rd_sel == SEL_OFFS) ? {{PAD_W{1'b0}}, offs_q} : base_q;
endmodule

// File: rtl/fpag_sva.sv
module fpag_sva #(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic              reg_wr_sel,
  input logic [ADDR_W-1:0] reg_wdata,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic              acc_is_wr,
  input logic [1:0]        acc_mode,
  input logic              fp_valid,
  input logic              fp_ready,
  input logic [ADDR_W-1:0] fp_addr,
  input logic [OFFS_W-1:0] offs_out,
  input logic [ADDR_W-1:0] base_q
);
  localparam int PAD_W = ADDR_W - OFFS_W;

  logic fire, offs_wr;
  logic [ADDR_W-1:0] offs_ext;
  assign fire     = acc_valid && acc_ready;
  assign offs_wr  = reg_wr_en && reg_wr_sel;
  assign offs_ext = {{PAD_W{1'b0}}, offs_out};

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fp_valid && !fp_ready |=> fp_valid && $stable(fp_addr));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fire && !offs_wr |=> $stable(offs_out));

  p_rd_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !acc_is_wr && (acc_mode == 2'b00) |=>
      fp_addr == ADDR_W'($past(base_q) + $past(offs_ext)));

  p_rd_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !acc_is_wr && acc_mode == 2'b01 && !offs_wr |=>
      offs_out == OFFS_W'($past(offs_out) + OFFS_W'(1)));

  p_wr_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && acc_is_wr && acc_mode == 2'b10 && !offs_wr |=>
      offs_out == OFFS_W'($past(offs_out) - OFFS_W'(1)) &&
      fp_addr == ADDR_W'($past(base_q) + $past(offs_ext) - ADDR_W'(1) +
                         ($past(offs_out) == '0 ? ADDR_W'(1 << OFFS_W) : ADDR_W'(0))));

  p_base_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_en |=> $stable(base_q));

  p_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (acc_mode == 2'b00 || acc_mode == 2'b11) && !offs_wr |=> $stable(offs_out));

  p_wr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    offs_wr |=> offs_out == $past(reg_wdata[OFFS_W-1:0]));
endmodule

bind fpag_top fpag_sva #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr_en  (reg_wr_en),
  .reg_wr_sel (reg_wr_sel),
  .reg_wdata  (reg_wdata),
  .acc_valid  (acc_valid),
  .acc_ready  (acc_ready),
  .acc_is_wr  (acc_is_wr),
  .acc_mode   (acc_mode),
  .fp_valid   (fp_valid),
  .fp_ready   (fp_ready),
  .fp_addr    (fp_addr),
  .offs_out   (offs_out),
  .base_q     (base_q)
);

// File: tb/fpag_top_tb.sv
module fpag_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_wr_sel = 1'b0, reg_rd_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        acc_valid = 1'b0, acc_is_wr = 1'b0;
  logic        acc_ready;
  logic [1:0]  acc_mode = 2'b00;
  logic        fp_valid;
  logic        fp_ready = 1'b1;
  logic [15:0] fp_addr;
  logic [7:0]  offs_out;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic [15:0] m_base = '0;
  logic [7:0]  m_offs = '0;
  logic        m_v = 1'b0;
  logic [15:0] m_addr = '0;

  always #10 clk = ~clk;

  fpag_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wdata(reg_wdata),
    .reg_rd_sel(reg_rd_sel), .reg_rdata(reg_rdata),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_is_wr(acc_is_wr),
    .acc_mode(acc_mode), .fp_valid(fp_valid), .fp_ready(fp_ready),
    .fp_addr(fp_addr), .offs_out(offs_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog expired: act=%0d exp<=20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [7:0] stepped(logic [7:0] o, logic [1:0] m);
    if (m == 2'b01) return o + 8'd1;
    if (m == 2'b10) return o - 8'd1;
    return o;
  endfunction

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit av, bit wr, logic [1:0] md, bit we, bit ws,
                      logic [15:0] wd, bit rdy, bit rs);
    bit ready, fire, wrap, ovf;
    logic [7:0]  mod, n_offs;
    logic [15:0] addr, n_base;
    logic [16:0] wide;
    @(negedge clk);
    acc_valid = av; acc_is_wr = wr; acc_mode = md;
    reg_wr_en = we; reg_wr_sel = ws; reg_wdata = wd;
    fp_ready = rdy; reg_rd_sel = rs;
    ready = !m_v || rdy;
    fire  = av && ready;
    mod   = stepped(m_offs, md);
    wide  = {1'b0, m_base} + {9'd0, (wr ? mod : m_offs)};
    addr  = wide[15:0];
    ovf   = wide[16];
    wrap  = fire && ((md == 2'b01 && m_offs == 8'hFF) || (md == 2'b10 && m_offs == 8'h00));
    n_offs = (we && ws) ? wd[7:0] : (fire ? mod : m_offs);
    n_base = (we && !ws) ? wd : m_base;
    #1;
    check(acc_ready == ready, "R9 acc_ready", {15'd0, acc_ready}, {15'd0, ready});
    @(posedge clk); #1;
    if (fire) begin m_v = 1'b1; m_addr = addr; end
    else if (rdy) m_v = 1'b0;
    m_offs = n_offs; m_base = n_base;
    check(fp_valid == m_v, "R9 fp_valid", {15'd0, fp_valid}, {15'd0, m_v});
    if (m_v)
      check(fp_addr == m_addr,
            fire ? (ovf ? "R10 addr wrap" : (wr ? "R5 write addr" : "R3 read addr")) : "R9 held addr",
            fp_addr, m_addr);
    check(offs_out == m_offs,
          (we && ws) ? (fire ? "R8 offset write wins" : "R2 offset write") :
          !fire ? "R9 offset idle" : wrap ? "R6 offset wrap" :
          (md == 2'b00 || md == 2'b11) ? "R7 offset none" : wr ? "R5 pre-step" : "R4 post-step",
          {8'd0, offs_out}, {8'd0, m_offs});
    check(reg_rdata == (rs ? {8'd0, m_offs} : m_base),
          (wrap && !rs) ? "R6 base unchanged" : "R2 readback",
          reg_rdata, rs ? {8'd0, m_offs} : m_base);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check(fp_valid == 1'b0, "R1 valid", {15'd0, fp_valid}, 16'd0);
    check(offs_out == 8'h00, "R1 offset", {8'd0, offs_out}, 16'd0);
    check(reg_rdata == 16'h0000, "R1 base", reg_rdata, 16'd0);
    @(negedge clk); rst_n = 1'b1;

    // base near top, offset 20h: sum carries past bit 15
    step(0, 0, 2'b00, 1, 0, 16'hFFF0, 1, 0);
    step(0, 0, 2'b00, 1, 1, 16'h0020, 1, 1);
    step(1, 0, 2'b00, 0, 0, 16'h0000, 1, 1);          // R10 addr 0010
    step(1, 0, 2'b01, 0, 0, 16'h0000, 1, 1);          // R4 read inc
    step(1, 1, 2'b01, 0, 0, 16'h0000, 1, 1);          // R5 write inc
    step(1, 1, 2'b11, 0, 0, 16'h0000, 1, 1);          // R7 mode 11
    // wrap up from FFh on write, base check
    step(0, 0, 2'b00, 1, 0, 16'h1000, 1, 0);
    step(0, 0, 2'b00, 1, 1, 16'h00FF, 1, 0);
    step(1, 1, 2'b01, 0, 0, 16'h0000, 1, 0);          // R6 addr 1000, offs 00
    step(1, 0, 2'b10, 0, 0, 16'h0000, 1, 0);          // R6 addr 1000, offs FF
    step(1, 1, 2'b10, 0, 0, 16'h0000, 1, 1);          // R5 write dec
    // collision: write wins
    step(1, 1, 2'b01, 1, 1, 16'h0042, 1, 1);          // R8
    // stall: hold addr, refused access leaves offset
    step(1, 0, 2'b01, 0, 0, 16'h0000, 0, 1);
    step(1, 0, 2'b01, 0, 0, 16'h0000, 0, 1);          // R9 refused
    step(1, 1, 2'b10, 0, 0, 16'h0000, 0, 1);
    step(0, 0, 2'b00, 0, 0, 16'h0000, 1, 1);

    for (int i = 0; i < 600; i++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
           2'($urandom_range(0, 3)), $urandom_range(0, 4) == 0,
           $urandom_range(0, 1) == 1, 16'($urandom),
           $urandom_range(0, 9) < 7, $urandom_range(0, 1) == 1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule